// File: doc/BRIEF.md
# Memory-Device Test Access Port with Identification Word

This block is the boundary-scan test port of a synchronous memory device. A five-signal-style serial interface (test clock, mode select, serial in, serial out plus an output enable for the serial out) drives the standard sixteen-state controller. Through it a tester can load a 3-bit instruction and then shift one of three data paths: a single-bit bypass stage, a fixed 32-bit identification word, or a 109-cell boundary chain. The chain covers 108 device pins and ends in one internal control cell.

Besides the serial paths, the block has two registered controls for the pad ring. The first asks the data-output drivers to float. The second makes the pads take their values from the boundary update latches rather than from the memory core. The drive values themselves come out in parallel. There is no dedicated test-reset pin: a power-on reset (`rst`, synchronous, active high) and five consecutive clocks with mode select high both return the port to its reset state.

Top module: `tap_port`

## Requirements
- R1: While `rst` is high and after it is released, the controller is in Test-Logic-Reset and the identification instruction is active. `out_float`, `scan_drive_en` and `tdo_en` are 0, and the first data scan returns the identification word.
- R2: Five consecutive TCK rising edges with `tms`=1 bring the controller to Test-Logic-Reset from any state, and this reselects the identification instruction.
- R3: The instruction register is 3 bits and shifts least significant bit first. Capture-IR loads 3'b001, so the first three bits out of `tdo` during an instruction scan are 1, 0, 0.
- R4: Instruction codes: 3'b000 external test, 3'b001 identification, 3'b010 sample-with-float, 3'b100 sample, 3'b111 bypass. The unused codes 3'b011, 3'b101 and 3'b110 select the bypass stage.
- R5: The identification word is {revision[2:0], configuration[16:0], maker[10:0], 1'b1}, shifted out bit 0 first. The configuration field is {11'b0, width_code[1:0], dll, quad, burst4, sep_io}, with width_code 2'b11 for 36-bit and 2'b10 for 18-bit data.
- R6: The bypass stage captures 0 and then delays `tdi` by one shift.
- R7: The boundary chain has 109 cells. Cell i (i from 0 to 107) captures `pin_sample[i]`, and cell 0 is shifted out first. Cell 108 is the internal drive-enable cell; on capture it keeps its latched value.
- R8: Sample-with-float sets `out_float` to 1. Sample leaves `out_float` at 0 and `scan_drive_en` at 0.
- R9: External test sets `scan_drive_en`. At the Update-IR that loads external test, `out_float` becomes 1 unless the latched cell 108 is 1. An Update-DR alone does not change `out_float`.
- R10: Under any boundary instruction (codes 000, 010, 100), Update-DR copies the chain into the update latches. `scan_drive` shows latched cells 0 to 107.
- R11: `tdo` and `tdo_en` change on the falling edge of TCK. `tdo_en` is 1 only in Shift-IR and Shift-DR, and `tdo` is 0 whenever `tdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| pin_sample | input | 108 | Parallel pin values captured into cells 0 to 107 |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdo_en | output | 1 | Serial out driver enable |
| out_float | output | 1 | Request to float the data-output drivers |
| scan_drive_en | output | 1 | Pads take their values from the boundary latches |
| scan_drive | output | 108 | Boundary update latch values for cells 0 to 107 |

## Verification
`out_float` and `scan_drive_en` are due one TCK rising edge after the edge taken in Update-IR. `scan_drive` is due one rising edge after Update-DR. Every serial bit is due at the falling edge that follows the rising edge that moved or shifted it. The bench changes inputs only after a falling edge and reads every output 1 ns after that falling edge. As a result, each sample sees exactly one new rising edge and one new falling edge. The scan tasks record `tdo` before the shifting edge, so bit k of a capture is read in the k-th shift cycle with no offset. Instructions are run from a vector table that holds each code's expected path and pad controls. Directed scans then cover the drive-enable cell and the five-cycle return to reset.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    S_TLR, S_IDLE,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_t;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ  = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BND} dr_sel_t;

  function automatic dr_sel_t decode_sel(logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPZ, OP_SAMPLE: decode_sel = SEL_BND;
      OP_IDCODE:                      decode_sel = SEL_ID;
      default:                        decode_sel = SEL_BYP;
    endcase
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t state
);

  tap_state_t nxt;

  always_comb begin
    case (state)
      S_TLR:    nxt = tms ? S_TLR    : S_IDLE;
      S_IDLE:   nxt = tms ? S_SEL_DR : S_IDLE;
      S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nxt = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: nxt = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: nxt = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: nxt = tms ? S_SEL_DR : S_IDLE;
      S_SEL_IR: nxt = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nxt = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: nxt = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: nxt = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: nxt = tms ? S_SEL_DR : S_IDLE;
      default:  nxt = S_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= S_TLR;
    else     state <= nxt;
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst,
  input  tap_state_t      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir,
  output logic [IR_W-1:0] ir_sh
);

  always_ff @(posedge tck) begin
    if (rst) begin
      ir    <= OP_IDCODE;
      ir_sh <= '0;
    end else begin
      case (state)
        S_TLR:    ir    <= OP_IDCODE;
        S_CAP_IR: ir_sh <= IR_CAPTURE;
        S_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        S_UPD_IR: ir    <= ir_sh;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int          NPINS   = 108,
  parameter int          ID_W    = 32,
  parameter logic [31:0] ID_WORD = 32'h0000_0001,
  localparam int         BND_LEN = NPINS + 1
) (
  input  logic               tck,
  input  logic               rst,
  input  tap_state_t         state,
  input  logic [IR_W-1:0]    ir,
  input  logic               tdi,
  input  logic [NPINS-1:0]   pin_sample,
  output logic               dr_lsb,
  output logic [BND_LEN-1:0] upd
);

  dr_sel_t            sel;
  logic               byp;
  logic [ID_W-1:0]    id_sh;
  logic [BND_LEN-1:0] bnd_sh;

  assign sel = decode_sel(ir);

  always_ff @(posedge tck) begin
    if (rst) begin
      byp    <= 1'b0;
      id_sh  <= '0;
      bnd_sh <= '0;
      upd    <= '0;
    end else begin
      case (state)
        S_CAP_DR: begin
          case (sel)
            SEL_ID:  id_sh  <= ID_WORD[ID_W-1:0];
            SEL_BND: bnd_sh <= {upd[NPINS], pin_sample};
            default: byp    <= 1'b0;
          endcase
        end
        S_SH_DR: begin
          case (sel)
            SEL_ID:  id_sh  <= {tdi, id_sh[ID_W-1:1]};
            SEL_BND: bnd_sh <= {tdi, bnd_sh[BND_LEN-1:1]};
            default: byp    <= tdi;
          endcase
        end
        S_UPD_DR: if (sel == SEL_BND) upd <= bnd_sh;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_ID:  dr_lsb = id_sh[0];
      SEL_BND: dr_lsb = bnd_sh[0];
      default: dr_lsb = byp;
    endcase
  end

endmodule

// File: rtl/tap_port.sv
module tap_port
  import tap_pkg::*;
#(
  parameter int          NPINS      = 108,
  parameter logic [2:0]  REVISION   = 3'b000,
  parameter logic [10:0] MAKER      = 11'h0D5,
  parameter logic [1:0]  WIDTH_CODE = 2'b11,
  parameter logic        HAS_DLL    = 1'b1,
  parameter logic        QUAD_MODE  = 1'b1,
  parameter logic        BURST4     = 1'b1,
  parameter logic        SEP_IO     = 1'b1
) (
  input  logic             tck,
  input  logic             rst,
  input  logic             tms,
  input  logic             tdi,
  input  logic [NPINS-1:0] pin_sample,
  output logic             tdo,
  output logic             tdo_en,
  output logic             out_float,
  output logic             scan_drive_en,
  output logic [NPINS-1:0] scan_drive
);

  localparam int          BND_LEN = NPINS + 1;
  localparam logic [16:0] CFG     = {11'b0, WIDTH_CODE, HAS_DLL, QUAD_MODE, BURST4, SEP_IO};
  localparam logic [31:0] ID_WORD = {REVISION, CFG, MAKER, 1'b1};

  tap_state_t         state;
  logic [IR_W-1:0]    ir;
  logic [IR_W-1:0]    ir_sh;
  logic               dr_lsb;
  logic [BND_LEN-1:0] upd;

  tap_fsm u_fsm (.tck(tck), .rst(rst), .tms(tms), .state(state));

  tap_ir u_ir (.tck(tck), .rst(rst), .state(state), .tdi(tdi), .ir(ir), .ir_sh(ir_sh));

  tap_dr #(.NPINS(NPINS), .ID_W(32), .ID_WORD(ID_WORD)) u_dr (
    .tck(tck), .rst(rst), .state(state), .ir(ir), .tdi(tdi),
    .pin_sample(pin_sample), .dr_lsb(dr_lsb), .upd(upd)
  );

  assign scan_drive = upd[NPINS-1:0];

  // pad controls are decided only when a new instruction becomes current
  always_ff @(posedge tck) begin
    if (rst || state == S_TLR) begin
      out_float     <= 1'b0;
      scan_drive_en <= 1'b0;
    end else if (state == S_UPD_IR) begin
      scan_drive_en <= (ir_sh == OP_EXTEST);
      out_float     <= (ir_sh == OP_SAMPZ) || (ir_sh == OP_EXTEST && !upd[NPINS]);
    end
  end

  // serial output retimed to the falling edge
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state == S_SH_IR) || (state == S_SH_DR);
      tdo    <= (state == S_SH_IR) ? ir_sh[0] :
                (state == S_SH_DR) ? dr_lsb : 1'b0;
    end
  end

endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
  import tap_pkg::*;
(
  input logic            tck,
  input logic            rst,
  input logic            tms,
  input logic            tdo,
  input logic            tdo_en,
  input logic            out_float,
  input tap_state_t      state,
  input logic [IR_W-1:0] ir,
  input logic [IR_W-1:0] ir_sh
);

  p_tlr_idcode_r1: assert property (@(posedge tck) disable iff (rst)
    state == S_TLR |=> ir == OP_IDCODE);

  p_five_ones_r2: assert property (@(posedge tck) disable iff (rst)
    ($past(tms,1) && $past(tms,2) && $past(tms,3) && $past(tms,4) && $past(tms,5))
      |-> state == S_TLR);

  p_ir_capture_r3: assert property (@(posedge tck) disable iff (rst)
    state == S_CAP_IR |=> ir_sh == IR_CAPTURE);

  p_sampz_float_r8: assert property (@(posedge tck) disable iff (rst)
    ir == OP_SAMPZ |-> out_float);

  p_float_at_ir_update_r9: assert property (@(posedge tck) disable iff (rst)
    out_float != $past(out_float) |-> ($past(state) == S_UPD_IR || $past(state) == S_TLR));

  p_tdo_quiet_r11: assert property (@(posedge tck) disable iff (rst)
    !tdo_en |-> !tdo);

endmodule

bind tap_port tap_port_chk u_chk (
  .tck(tck), .rst(rst), .tms(tms), .tdo(tdo), .tdo_en(tdo_en),
  .out_float(out_float), .state(state), .ir(ir), .ir_sh(ir_sh)
);

// File: tb/tap_port_tb.sv
`timescale 1ns/1ps
module tap_port_tb;

  localparam logic [2:0]  REV = 3'b010;
  localparam logic [10:0] MK  = 11'h0D5;
  localparam logic [31:0] EXP_ID = {REV, 11'b0, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1, MK, 1'b1};

  logic         clk = 1'b0;
  logic         rst, tms, tdi;
  logic [107:0] pins;
  logic         tdo, tdo_en, out_float, scan_drive_en;
  logic [107:0] scan_drive;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tap_port #(.REVISION(REV), .MAKER(MK)) u_dut (
    .tck(clk), .rst(rst), .tms(tms), .tdi(tdi), .pin_sample(pins),
    .tdo(tdo), .tdo_en(tdo_en), .out_float(out_float),
    .scan_drive_en(scan_drive_en), .scan_drive(scan_drive)
  );

  // code, path kind (0 bypass, 1 id, 2 boundary), float, drive-enable
  localparam logic [6:0] VEC [8] = '{
    {3'b000, 2'd2, 1'b1, 1'b1},
    {3'b001, 2'd1, 1'b0, 1'b0},
    {3'b010, 2'd2, 1'b1, 1'b0},
    {3'b011, 2'd0, 1'b0, 1'b0},
    {3'b100, 2'd2, 1'b0, 1'b0},
    {3'b101, 2'd0, 1'b0, 1'b0},
    {3'b110, 2'd0, 1'b0, 1'b0},
    {3'b111, 2'd0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      step(i == 2, code[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [127:0] din,
                         output logic [127:0] dout, output logic en);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    en = tdo_en;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [2:0]   cap;
    logic [127:0] out;
    logic [127:0] din;
    logic         en;
    logic [107:0] pat;
    rst = 1; tms = 0; tdi = 0; pins = '0;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 float in reset", out_float, 0);
    rst = 0;
    @(negedge clk); #1;
    chk("R1 drive_en after reset", scan_drive_en, 0);
    chk("R11 tdo_en idle", tdo_en, 0);
    step(0, 0);
    scan_dr(32, '0, out, en);
    chk("R1 R5 id after reset", out[31:0], EXP_ID);
    chk("R11 tdo_en in shift", en, 1);
    chk("R11 tdo_en after shift", tdo_en, 0);

    pat = {3{36'h9_3C5A_17E2}};
    for (int v = 0; v < 8; v++) begin
      logic [2:0] code;
      code = VEC[v][6:4];
      load_ir(code, cap);
      chk("R3 capture-ir", cap, 3'b001);
      chk("R4 R8 R9 float", out_float, VEC[v][1]);
      chk("R4 R9 drive_en", scan_drive_en, VEC[v][0]);
      case (VEC[v][3:2])
        2'd1: begin
          scan_dr(32, '0, out, en);
          chk("R5 id word", out[31:0], EXP_ID);
        end
        2'd2: begin
          pins = pat;
          scan_dr(109, '0, out, en);
          chk("R7 boundary capture", out[107:0], pat);
          chk("R7 cell108", out[108], 0);
          chk("R10 update copies", scan_drive, '0);
          pat = {pat[0], pat[107:1]};
        end
        default: begin
          din = 128'hB3;
          scan_dr(8, din, out, en);
          chk("R6 bypass", out[7:0], 8'h66);
        end
      endcase
    end

    // drive-enable cell and Update-IR timing
    load_ir(3'b000, cap);
    chk("R9 extest floats", out_float, 1);
    din = '0;
    din[107:0] = 108'h5A5_0F0F_1234_5678_9ABC_DEF0_1357;
    din[108] = 1'b1;
    scan_dr(109, din, out, en);
    chk("R10 drive latches", scan_drive, din[107:0]);
    chk("R9 dr update leaves float", out_float, 1);
    load_ir(3'b000, cap);
    chk("R9 cell108 drives", out_float, 0);
    chk("R9 extest drive_en", scan_drive_en, 1);
    load_ir(3'b100, cap);
    chk("R8 sample no float", out_float, 0);
    chk("R8 sample no drive", scan_drive_en, 0);
    load_ir(3'b010, cap);
    chk("R8 sample-z floats", out_float, 1);

    // five ones from mid-scan
    load_ir(3'b111, cap);
    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < 5; k++) step(1, 0);
    chk("R2 float cleared", out_float, 0);
    step(0, 0);
    scan_dr(32, '0, out, en);
    chk("R2 idcode reselected", out[31:0], EXP_ID);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule